// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the per-source state for a bank of interrupt inputs and decides when each source is offered to a downstream presentation controller. Each input is fixed at build time as either level-type or message-type. Every source keeps a destination server, a current priority in which the value 0xFF masks the source, a saved priority, and four status flags. Sources are numbered globally starting at a base number set by a parameter.

The presentation side hands back three kinds of notification. A reject names a source that could not be taken. An EOI names a source whose service is finished. A resend request makes the block walk the bank one source per clock and re-offer whatever is eligible. A single configuration port writes server and priority, masks a source while keeping its old priority, restores that saved priority, and reads back server, priority and flags. Each request gets a status byte one cycle later.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset no offer is presented, every source reads back priority 0xFF, and all its flags are zero.
- R2: A configuration read (op 1) returns the server, the priority and a 4-bit flag field. In that field bit 0 is asserted, bit 1 is sent, bit 2 is rejected and bit 3 is masked-pending. A write (op 0) sets server, priority and saved priority.
- R3: An event on an unmasked message-type source leads to an offer of that source's global number, server and priority. An offer never carries priority 0xFF.
- R4: An event on a masked message-type source sets masked-pending and makes no offer. A later write or restore that leaves the source unmasked clears masked-pending and offers the source.
- R5: For a level-type source, the asserted flag follows the input. The source is offered only when it is unmasked, asserted and not sent. This is tested on a rising input, on any write, mask or restore, and on a resend visit. Sent is set at that test, so a held input does not offer twice.
- R6: A reject naming a source sets its rejected flag and clears its sent flag, and makes no offer.
- R7: A resend visits the sources one per clock. A message-type source with rejected set has the flag cleared and is re-offered if unmasked. A level-type source gets the R5 test. A new resend request restarts the walk at the first source.
- R8: An EOI clears sent on a level-type source and makes no offer. On a message-type source it changes nothing.
- R9: The mask operation (op 2) copies the priority into the saved priority and sets the priority to 0xFF. The restore operation (op 3) copies the saved priority back into the priority.
- R10: A request whose source number lies outside base to base + count - 1 returns status 0xFD (-3). So does a write whose server is not below the server count. Such a request changes no state. Every other request returns 0x00.
- R11: An offer stays valid with unchanged fields until ready is high. When several sources are eligible, the lowest-numbered one is offered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level for level-type sources, one-cycle event for message-type |
| offer_valid_o | output | 1 | Offer present |
| offer_ready_i | input | 1 | Presentation side takes the offer |
| offer_src_o | output | NUM_W | Global source number of the offer |
| offer_srv_o | output | SRV_W | Destination server of the offer |
| offer_prio_o | output | 8 | Priority of the offer |
| rej_valid_i | input | 1 | Reject notification |
| rej_src_i | input | NUM_W | Global number of the rejected source |
| eoi_valid_i | input | 1 | EOI notification |
| eoi_src_i | input | NUM_W | Global number of the source ending service |
| resend_i | input | 1 | Start a resend walk |
| cfg_valid_i | input | 1 | Configuration request |
| cfg_op_i | input | 2 | 0 write, 1 read, 2 mask, 3 restore |
| cfg_src_i | input | NUM_W | Global source number of the request |
| cfg_srv_i | input | SRV_W | Server for a write |
| cfg_prio_i | input | 8 | Priority for a write |
| cfg_rsp_valid_o | output | 1 | Response present, one cycle after the request |
| cfg_status_o | output | 8 | 0x00 success, 0xFD bad source or server |
| cfg_srv_o | output | SRV_W | Server returned by a read |
| cfg_prio_o | output | 8 | Priority returned by a read |
| cfg_flags_o | output | 4 | Flags returned by a read |

## Verification
The hardest states to reach from the ports are the ones where a source is waiting for another trigger. One is a rejected message source. Another is a level source whose sent flag was cleared by a reject or an EOI while its input stays high. In both cases nothing should happen until a resend visits the source. The bench gets there by letting an offer be taken, sending a reject or an EOI, and then reading the flags to confirm the parked state. It also watches the offer port for several cycles to confirm that nothing is offered. Only after that does it issue a resend and expect exactly one offer. Masked-pending is reached the same way, by sending an event while the source is masked and then restoring it.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  typedef enum logic [1:0] {
    CFG_WRITE = 2'd0,
    CFG_READ  = 2'd1,
    CFG_OFF   = 2'd2,
    CFG_ON    = 2'd3
  } cfg_op_e;

  localparam int FL_ASSERTED = 0;
  localparam int FL_SENT     = 1;
  localparam int FL_REJECTED = 2;
  localparam int FL_MPEND    = 3;

  localparam logic [7:0] PRIO_MASKED = 8'hFF;
  localparam logic [7:0] STATUS_OK   = 8'h00;
  localparam logic [7:0] STATUS_BAD  = 8'hFD;
endpackage

// File: rtl/src_slot.sv
module src_slot
  import irq_src_pkg::*;
#(
  parameter int SRV_W    = 2,
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_i,
  input  logic             cfg_hit_i,
  input  cfg_op_e          cfg_op_i,
  input  logic [SRV_W-1:0] cfg_srv_i,
  input  logic [7:0]       cfg_prio_i,
  input  logic             rej_hit_i,
  input  logic             eoi_hit_i,
  input  logic             scan_hit_i,
  input  logic             take_i,
  output logic             want_o,
  output logic [SRV_W-1:0] srv_o,
  output logic [7:0]       prio_o,
  output logic [3:0]       flags_o
);
  logic [SRV_W-1:0] srv_q, srv_n;
  logic [7:0]       prio_q, prio_n, saved_q, saved_n;
  logic [3:0]       fl_q, fl_n;
  logic             pend_q, pend_n;

  always_comb begin
    srv_n   = srv_q;
    prio_n  = prio_q;
    saved_n = saved_q;
    fl_n    = fl_q;
    pend_n  = pend_q & ~take_i;

    if (cfg_hit_i) begin
      unique case (cfg_op_i)
        CFG_WRITE: begin
          srv_n   = cfg_srv_i;
          prio_n  = cfg_prio_i;
          saved_n = cfg_prio_i;
        end
        CFG_OFF: begin
          saved_n = prio_q;
          prio_n  = PRIO_MASKED;
        end
        CFG_ON:  prio_n = saved_q;
        default: ;
      endcase
    end

    if (rej_hit_i) begin
      fl_n[FL_REJECTED] = 1'b1;
      fl_n[FL_SENT]     = 1'b0;
    end

    if (IS_LEVEL) begin
      fl_n[FL_ASSERTED] = in_i;
      if (eoi_hit_i) fl_n[FL_SENT] = 1'b0;
      if ((in_i & ~fl_q[FL_ASSERTED]) | cfg_hit_i | scan_hit_i) begin
        if (prio_n != PRIO_MASKED && fl_n[FL_ASSERTED] && !fl_n[FL_SENT]) begin
          fl_n[FL_SENT] = 1'b1;
          pend_n        = 1'b1;
        end
      end
    end else begin
      if (in_i) begin
        if (prio_n == PRIO_MASKED) fl_n[FL_MPEND] = 1'b1;
        else                       pend_n = 1'b1;
      end
      if (cfg_hit_i && fl_n[FL_MPEND] && prio_n != PRIO_MASKED) begin
        fl_n[FL_MPEND] = 1'b0;
        pend_n         = 1'b1;
      end
      if (scan_hit_i && fl_n[FL_REJECTED]) begin
        fl_n[FL_REJECTED] = 1'b0;
        if (prio_n != PRIO_MASKED) pend_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srv_q   <= '0;
      prio_q  <= PRIO_MASKED;
      saved_q <= PRIO_MASKED;
      fl_q    <= '0;
      pend_q  <= 1'b0;
    end else begin
      srv_q   <= srv_n;
      prio_q  <= prio_n;
      saved_q <= saved_n;
      fl_q    <= fl_n;
      pend_q  <= pend_n;
    end
  end

  assign want_o  = pend_q && (prio_q != PRIO_MASKED);
  assign srv_o   = srv_q;
  assign prio_o  = prio_q;
  assign flags_o = fl_q;
endmodule

// File: rtl/resend_scan.sv
module resend_scan #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic [NUM_SRC-1:0] hit_o
);
  logic             act_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      idx_q <= '0;
    end else if (act_q) begin
      if (idx_q == IDX_W'(NUM_SRC - 1)) act_q <= 1'b0;
      else                              idx_q <= idx_q + 1'b1;
    end
  end

  always_comb begin
    hit_o = '0;
    if (act_q) hit_o[idx_q] = 1'b1;
  end
endmodule

// File: rtl/offer_arb.sv
module offer_arb #(
  parameter int NUM_SRC = 8,
  parameter int SRV_W   = 2,
  parameter int NUM_W   = 8,
  parameter int OFFSET  = 16,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_SRC-1:0]              want_i,
  input  logic [NUM_SRC-1:0][SRV_W-1:0]   srv_i,
  input  logic [NUM_SRC-1:0][7:0]         prio_i,
  input  logic                            ready_i,
  output logic [NUM_SRC-1:0]              take_o,
  output logic                            valid_o,
  output logic [NUM_W-1:0]                src_o,
  output logic [SRV_W-1:0]                srv_o,
  output logic [7:0]                      prio_o
);
  logic [IDX_W-1:0] sel;
  logic             any, load;

  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (want_i[i]) begin
        sel = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

  assign load = any && (!valid_o || ready_i);

  always_comb begin
    take_o = '0;
    if (load) take_o[sel] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      src_o   <= '0;
      srv_o   <= '0;
      prio_o  <= '0;
    end else if (load) begin
      valid_o <= 1'b1;
      src_o   <= NUM_W'(OFFSET) + NUM_W'(sel);
      srv_o   <= srv_i[sel];
      prio_o  <= prio_i[sel];
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC                  = 8,
  parameter int NUM_SRV                  = 3,
  parameter int OFFSET                   = 16,
  parameter int NUM_W                    = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hF0,
  localparam int SRV_W = (NUM_SRV > 1) ? $clog2(NUM_SRV) : 1,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               offer_valid_o,
  input  logic               offer_ready_i,
  output logic [NUM_W-1:0]   offer_src_o,
  output logic [SRV_W-1:0]   offer_srv_o,
  output logic [7:0]         offer_prio_o,
  input  logic               rej_valid_i,
  input  logic [NUM_W-1:0]   rej_src_i,
  input  logic               eoi_valid_i,
  input  logic [NUM_W-1:0]   eoi_src_i,
  input  logic               resend_i,
  input  logic               cfg_valid_i,
  input  logic [1:0]         cfg_op_i,
  input  logic [NUM_W-1:0]   cfg_src_i,
  input  logic [SRV_W-1:0]   cfg_srv_i,
  input  logic [7:0]         cfg_prio_i,
  output logic               cfg_rsp_valid_o,
  output logic [7:0]         cfg_status_o,
  output logic [SRV_W-1:0]   cfg_srv_o,
  output logic [7:0]         cfg_prio_o,
  output logic [3:0]         cfg_flags_o
);
  function automatic logic in_rng(logic [NUM_W-1:0] n);
    return (int'(n) >= OFFSET) && (int'(n) < OFFSET + NUM_SRC);
  endfunction

  function automatic logic [IDX_W-1:0] to_idx(logic [NUM_W-1:0] n);
    return IDX_W'(n - NUM_W'(OFFSET));
  endfunction

  cfg_op_e          op;
  logic             cfg_ok, cfg_mut;
  logic [IDX_W-1:0] cfg_idx, rej_idx, eoi_idx;

  assign op      = cfg_op_e'(cfg_op_i);
  assign cfg_idx = to_idx(cfg_src_i);
  assign rej_idx = to_idx(rej_src_i);
  assign eoi_idx = to_idx(eoi_src_i);
  assign cfg_ok  = in_rng(cfg_src_i) && (op != CFG_WRITE || int'(cfg_srv_i) < NUM_SRV);
  assign cfg_mut = cfg_valid_i && cfg_ok && (op != CFG_READ);

  logic [NUM_SRC-1:0]            want, take, scan_hit;
  logic [NUM_SRC-1:0][SRV_W-1:0] srv_a;
  logic [NUM_SRC-1:0][7:0]       prio_a;
  logic [NUM_SRC-1:0][3:0]       flags_a;

  resend_scan #(.NUM_SRC(NUM_SRC)) u_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (resend_i),
    .hit_o   (scan_hit)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    src_slot #(.SRV_W(SRV_W), .IS_LEVEL(LEVEL_MASK[g])) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_i       (src_i[g]),
      .cfg_hit_i  (cfg_mut && cfg_idx == IDX_W'(g)),
      .cfg_op_i   (op),
      .cfg_srv_i  (cfg_srv_i),
      .cfg_prio_i (cfg_prio_i),
      .rej_hit_i  (rej_valid_i && in_rng(rej_src_i) && rej_idx == IDX_W'(g)),
      .eoi_hit_i  (eoi_valid_i && in_rng(eoi_src_i) && eoi_idx == IDX_W'(g)),
      .scan_hit_i (scan_hit[g]),
      .take_i     (take[g]),
      .want_o     (want[g]),
      .srv_o      (srv_a[g]),
      .prio_o     (prio_a[g]),
      .flags_o    (flags_a[g])
    );
  end

  offer_arb #(
    .NUM_SRC (NUM_SRC),
    .SRV_W   (SRV_W),
    .NUM_W   (NUM_W),
    .OFFSET  (OFFSET)
  ) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .want_i  (want),
    .srv_i   (srv_a),
    .prio_i  (prio_a),
    .ready_i (offer_ready_i),
    .take_o  (take),
    .valid_o (offer_valid_o),
    .src_o   (offer_src_o),
    .srv_o   (offer_srv_o),
    .prio_o  (offer_prio_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_rsp_valid_o <= 1'b0;
      cfg_status_o    <= STATUS_OK;
      cfg_srv_o       <= '0;
      cfg_prio_o      <= '0;
      cfg_flags_o     <= '0;
    end else begin
      cfg_rsp_valid_o <= cfg_valid_i;
      cfg_status_o    <= cfg_ok ? STATUS_OK : STATUS_BAD;
      if (cfg_valid_i && cfg_ok && op == CFG_READ) begin
        cfg_srv_o   <= srv_a[cfg_idx];
        cfg_prio_o  <= prio_a[cfg_idx];
        cfg_flags_o <= flags_a[cfg_idx];
      end else begin
        cfg_srv_o   <= '0;
        cfg_prio_o  <= '0;
        cfg_flags_o <= '0;
      end
    end
  end
endmodule

// File: rtl/irq_src_ctrl_chk.sv
module irq_src_ctrl_chk #(
  parameter int NUM_SRC = 8,
  parameter int OFFSET  = 16,
  parameter int NUM_W   = 8,
  parameter int SRV_W   = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             offer_valid_o,
  input logic             offer_ready_i,
  input logic [NUM_W-1:0] offer_src_o,
  input logic [SRV_W-1:0] offer_srv_o,
  input logic [7:0]       offer_prio_o,
  input logic             cfg_valid_i,
  input logic [NUM_W-1:0] cfg_src_i,
  input logic             cfg_rsp_valid_o,
  input logic [7:0]       cfg_status_o
);
  logic cfg_src_ok, offer_src_ok;
  assign cfg_src_ok   = (int'(cfg_src_i) >= OFFSET) && (int'(cfg_src_i) < OFFSET + NUM_SRC);
  assign offer_src_ok = (int'(offer_src_o) >= OFFSET) && (int'(offer_src_o) < OFFSET + NUM_SRC);

  AST_OFFER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offer_valid_o && !offer_ready_i |=> offer_valid_o && $stable(offer_src_o)
      && $stable(offer_srv_o) && $stable(offer_prio_o)); // R11
  AST_OFFER_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offer_valid_o |-> offer_prio_o != 8'hFF); // R3
  AST_OFFER_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offer_valid_o |-> offer_src_ok); // R3
  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rsp_valid_o |-> $past(cfg_valid_i)); // R10
  AST_BAD_SRC_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && !cfg_src_ok |=> cfg_rsp_valid_o && cfg_status_o == 8'hFD); // R10
  AST_STATUS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rsp_valid_o |-> (cfg_status_o == 8'h00 || cfg_status_o == 8'hFD)); // R10
endmodule

bind irq_src_ctrl irq_src_ctrl_chk #(
  .NUM_SRC (NUM_SRC),
  .OFFSET  (OFFSET),
  .NUM_W   (NUM_W),
  .SRV_W   (SRV_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .offer_valid_o   (offer_valid_o),
  .offer_ready_i   (offer_ready_i),
  .offer_src_o     (offer_src_o),
  .offer_srv_o     (offer_srv_o),
  .offer_prio_o    (offer_prio_o),
  .cfg_valid_i     (cfg_valid_i),
  .cfg_src_i       (cfg_src_i),
  .cfg_rsp_valid_o (cfg_rsp_valid_o),
  .cfg_status_o    (cfg_status_o)
);

// File: tb/tb_irq_src_ctrl.sv
module tb_irq_src_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] src_i = '0;
  logic       offer_valid_o, offer_ready_i = 1'b0;
  logic [7:0] offer_src_o, offer_prio_o;
  logic [1:0] offer_srv_o;
  logic       rej_valid_i = 1'b0, eoi_valid_i = 1'b0, resend_i = 1'b0;
  logic [7:0] rej_src_i = '0, eoi_src_i = '0;
  logic       cfg_valid_i = 1'b0;
  logic [1:0] cfg_op_i = '0, cfg_srv_i = '0;
  logic [7:0] cfg_src_i = '0, cfg_prio_i = '0;
  logic       cfg_rsp_valid_o;
  logic [7:0] cfg_status_o, cfg_prio_o;
  logic [1:0] cfg_srv_o;
  logic [3:0] cfg_flags_o;

  int checks = 0, errors = 0;
  logic [7:0] r_status, r_prio;
  logic [1:0] r_srv;
  logic [3:0] r_flags;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  irq_src_ctrl dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(logic [1:0] op, logic [7:0] src, logic [1:0] srv, logic [7:0] prio);
    cfg_valid_i = 1'b1; cfg_op_i = op; cfg_src_i = src; cfg_srv_i = srv; cfg_prio_i = prio;
    @(negedge clk_i);
    cfg_valid_i = 1'b0;
    r_status = cfg_status_o; r_srv = cfg_srv_o; r_prio = cfg_prio_o; r_flags = cfg_flags_o;
  endtask

  task automatic pulse_msg(logic [7:0] bits);
    src_i = src_i | bits;
    @(negedge clk_i);
    src_i = src_i & ~bits;
  endtask

  task automatic reject(logic [7:0] n);
    rej_valid_i = 1'b1; rej_src_i = n; @(negedge clk_i); rej_valid_i = 1'b0;
  endtask

  task automatic eoi(logic [7:0] n);
    eoi_valid_i = 1'b1; eoi_src_i = n; @(negedge clk_i); eoi_valid_i = 1'b0;
  endtask

  task automatic resend();
    resend_i = 1'b1; @(negedge clk_i); resend_i = 1'b0;
  endtask

  task automatic expect_offer(string tag, logic [7:0] src, logic [1:0] srv, logic [7:0] prio);
    for (int n = 0; n < 40 && !offer_valid_o; n++) @(negedge clk_i);
    chk({tag, " offer valid"}, offer_valid_o, 1);
    chk({tag, " offer src"}, offer_src_o, src);
    chk({tag, " offer srv"}, offer_srv_o, srv);
    chk({tag, " offer prio"}, offer_prio_o, prio);
    offer_ready_i = 1'b1;
    @(negedge clk_i);
    offer_ready_i = 1'b0;
  endtask

  task automatic expect_quiet(string tag, int cycles);
    logic seen = 1'b0;
    for (int n = 0; n < cycles; n++) begin
      if (offer_valid_o) seen = 1'b1;
      @(negedge clk_i);
    end
    chk({tag, " no offer"}, seen, 0);
  endtask

  task automatic t_reset();
    chk("R1 idle", offer_valid_o, 0);
    cfg(2'd1, 8'd16, 2'd0, 8'd0);
    chk("R1 prio", r_prio, 8'hFF);
    chk("R1 flags", r_flags, 0);
    cfg(2'd1, 8'd23, 2'd0, 8'd0);
    chk("R1 prio last", r_prio, 8'hFF);
  endtask

  task automatic t_msg();
    cfg(2'd0, 8'd16, 2'd2, 8'd5);
    chk("R10 write ok", r_status, 8'h00);
    cfg(2'd1, 8'd16, 2'd0, 8'd0);
    chk("R2 srv", r_srv, 2);
    chk("R2 prio", r_prio, 5);
    pulse_msg(8'h01);
    expect_offer("R3", 8'd16, 2'd2, 8'd5);
    expect_quiet("R3 single", 5);
  endtask

  task automatic t_masked();
    pulse_msg(8'h02);
    expect_quiet("R4 masked", 5);
    cfg(2'd1, 8'd17, 2'd0, 8'd0);
    chk("R4 mpend flag", r_flags, 4'h8);
    cfg(2'd0, 8'd17, 2'd1, 8'd3);
    expect_offer("R4 unmask", 8'd17, 2'd1, 8'd3);
    cfg(2'd1, 8'd17, 2'd0, 8'd0);
    chk("R4 mpend clear", r_flags, 4'h0);
  endtask

  task automatic t_level();
    cfg(2'd0, 8'd20, 2'd1, 8'd4);
    src_i[4] = 1'b1;
    expect_offer("R5", 8'd20, 2'd1, 8'd4);
    cfg(2'd1, 8'd20, 2'd0, 8'd0);
    chk("R5 flags", r_flags, 4'h3);
    expect_quiet("R5 held", 6);
    eoi(8'd20);
    cfg(2'd1, 8'd20, 2'd0, 8'd0);
    chk("R8 level sent cleared", r_flags, 4'h1);
    expect_quiet("R8 eoi", 5);
    resend();
    expect_offer("R7 level", 8'd20, 2'd1, 8'd4);
    src_i[4] = 1'b0;
    @(negedge clk_i);
    eoi(8'd20);
    cfg(2'd1, 8'd20, 2'd0, 8'd0);
    chk("R5 deasserted", r_flags, 4'h0);
  endtask

  task automatic t_reject();
    pulse_msg(8'h01);
    expect_offer("R6 msg", 8'd16, 2'd2, 8'd5);
    reject(8'd16);
    cfg(2'd1, 8'd16, 2'd0, 8'd0);
    chk("R6 rej flag", r_flags, 4'h4);
    expect_quiet("R6 msg", 5);
    resend();
    expect_offer("R7 msg", 8'd16, 2'd2, 8'd5);
    cfg(2'd1, 8'd16, 2'd0, 8'd0);
    chk("R7 rej cleared", r_flags, 4'h0);
    cfg(2'd0, 8'd21, 2'd0, 8'd6);
    src_i[5] = 1'b1;
    expect_offer("R6 lvl", 8'd21, 2'd0, 8'd6);
    reject(8'd21);
    cfg(2'd1, 8'd21, 2'd0, 8'd0);
    chk("R6 lvl flags", r_flags, 4'h5);
    expect_quiet("R6 lvl", 5);
    resend();
    expect_offer("R7 lvl", 8'd21, 2'd0, 8'd6);
    src_i[5] = 1'b0;
    @(negedge clk_i);
    eoi(8'd21);
  endtask

  task automatic t_eoi_msg();
    pulse_msg(8'h01);
    expect_offer("R8 msg", 8'd16, 2'd2, 8'd5);
    reject(8'd16);
    eoi(8'd16);
    cfg(2'd1, 8'd16, 2'd0, 8'd0);
    chk("R8 msg unchanged", r_flags, 4'h4);
    expect_quiet("R8 msg", 4);
    resend();
    expect_offer("R8 msg resend", 8'd16, 2'd2, 8'd5);
  endtask

  task automatic t_offon();
    cfg(2'd2, 8'd16, 2'd0, 8'd0);
    chk("R9 off ok", r_status, 8'h00);
    cfg(2'd1, 8'd16, 2'd0, 8'd0);
    chk("R9 off prio", r_prio, 8'hFF);
    pulse_msg(8'h01);
    expect_quiet("R9 off", 5);
    cfg(2'd1, 8'd16, 2'd0, 8'd0);
    chk("R9 mpend", r_flags, 4'h8);
    cfg(2'd3, 8'd16, 2'd0, 8'd0);
    expect_offer("R9 on", 8'd16, 2'd2, 8'd5);
    cfg(2'd1, 8'd16, 2'd0, 8'd0);
    chk("R9 restored", r_prio, 8'd5);
  endtask

  task automatic t_range();
    cfg(2'd1, 8'd15, 2'd0, 8'd0);
    chk("R10 below", r_status, 8'hFD);
    cfg(2'd1, 8'd24, 2'd0, 8'd0);
    chk("R10 above", r_status, 8'hFD);
    cfg(2'd0, 8'd18, 2'd3, 8'd1);
    chk("R10 bad srv", r_status, 8'hFD);
    cfg(2'd1, 8'd18, 2'd0, 8'd0);
    chk("R10 unchanged", r_prio, 8'hFF);
    cfg(2'd0, 8'd18, 2'd2, 8'd1);
    chk("R10 good srv", r_status, 8'h00);
  endtask

  task automatic t_arb();
    pulse_msg(8'h05);
    for (int n = 0; n < 10 && !offer_valid_o; n++) @(negedge clk_i);
    chk("R11 lowest first", offer_src_o, 16);
    repeat (3) @(negedge clk_i);
    chk("R11 held valid", offer_valid_o, 1);
    chk("R11 held src", offer_src_o, 16);
    expect_offer("R11 first", 8'd16, 2'd2, 8'd5);
    expect_offer("R11 second", 8'd18, 2'd2, 8'd1);
    expect_quiet("R11 drained", 4);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_msg();
    t_masked();
    t_level();
    t_reject();
    t_eoi_msg();
    t_offon();
    t_range();
    t_arb();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule